// File: doc/BRIEF.md
# Selectable-Source Fractional Clock Divider

This block produces a slow clock for loading configuration data. It takes two reference clocks, an on-chip oscillator and an external clock pin of up to 100 MHz, and picks one of them. It then divides the chosen clock by a programmable ratio. The ratio can be any whole number from 1 to 16, or one of two half-integer values, 1.5 and 2.5. Whole-number ratios always give a 50% duty cycle, odd ones included, because the divider places output edges on both rising and falling source edges. The half-integer ratios give an uneven duty cycle. The output frequency is the frequency of the selected source divided by the programmed ratio.

Software or a sequencer places a ratio code and a source choice on the inputs and then raises the load strobe. The divider waits until the output is in a low phase and holds the output low. It then switches the source through a glitch-free gate and restarts the output with the new ratio. A status bit is low while the switch is in progress and goes high again once the first full period at the new setting has been emitted.

Top module: `cfgclk_div`

## Requirements
- R1: With `src_sel` = 0 the output is derived from `clk_int`; with `src_sel` = 1 it is derived from `clk_ext`.
- R2: A `div_code` value c in 1..16 gives an output period of c source periods, with the output high for exactly c source half-periods (50% duty).
- R3: Code 17 gives a period of 3 source half-periods, high for 1. Code 18 gives a period of 5 source half-periods, high for 2.
- R4: Every other code (0 and 19..31) gives divide-by-1: the output follows the selected source, with a period of 2 half-periods and high for 1.
- R5: `div_code` and `src_sel` are taken only on a rising edge of `ld`. Changing them while `ld` is not rising leaves both the output period and `running` unchanged.
- R6: A new setting takes effect only from a low phase of the output, and the output is held low during the switchover. No output high or low pulse is ever shorter than one half-period of the faster source.
- R7: After a load, `running` falls. It rises again after the first complete output period at the new setting.
- R8: While `rst` is high, `clk_out` and `running` are low. After release the block runs at divide-by-1 from `clk_int` and raises `running`.
- R9: At most one reference clock is gated into the divider at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_int | input | 1 | Internal oscillator reference clock |
| clk_ext | input | 1 | External reference clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Source choice: 0 internal, 1 external |
| div_code | input | 5 | Ratio code: 1..16 integer, 17 = 1.5, 18 = 2.5, others = 1 |
| ld | input | 1 | Load strobe; its rising edge captures code and source |
| clk_out | output | 1 | Divided clock output |
| running | output | 1 | High once a full output period has been emitted at the current setting |

## Verification
The hardest case to provoke is a reload that arrives while the output is in the middle of a high phase and that also changes the source clock. Here the cut point, the gate handover between the two unrelated clocks and the restart all interact. The stimulus sweeps every code on both sources one after another, so each reload leaves a different ratio, and every second group of reloads switches clocks. The two source periods are co-prime to each other, so the load strobe lands at many different phases of the output. A monitor measures the width of every output pulse across all of these transitions.

// File: rtl/cfgclk_pkg.sv
package cfgclk_pkg;

  // Widths of the ratio code and of the half-period counters
  localparam int CODE_W = 5;
  localparam int HP_W   = 6;   // up to 32 half-periods per output period
  localparam int HI_W   = 5;   // up to 16 high half-periods

  localparam int MAX_INT_RATIO = 16;
  localparam int CODE_R1P5     = 17;
  localparam int CODE_R2P5     = 18;

  typedef struct packed {
    logic [HP_W-1:0] per;   // output period in source half-periods
    logic [HI_W-1:0] hi;    // high time in source half-periods
  } ratio_t;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } gen_st_t;

  function automatic ratio_t ratio_of(input logic [CODE_W-1:0] c);
    ratio_t r;
    if (c >= CODE_W'(1) && c <= CODE_W'(MAX_INT_RATIO)) begin
      r.per = HP_W'(c) << 1;
      r.hi  = HI_W'(c);
    end else if (c == CODE_W'(CODE_R1P5)) begin
      r.per = HP_W'(3);
      r.hi  = HI_W'(1);
    end else if (c == CODE_W'(CODE_R2P5)) begin
      r.per = HP_W'(5);
      r.hi  = HI_W'(2);
    end else begin
      r.per = HP_W'(2);
      r.hi  = HI_W'(1);
    end
    return r;
  endfunction

endpackage

// File: rtl/cfgclk_src_gate.sv
module cfgclk_src_gate #(
  parameter int N_SRC = 2,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] src_clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             mclk,
  output logic [N_SRC-1:0] en
);

  logic [N_SRC-1:0] gated;

  for (genvar i = 0; i < N_SRC; i++) begin : g_lane
    logic others_on;
    logic want;
    logic sync_q;
    logic en_q;

    // a lane may turn on only after every other lane has turned off
    assign others_on = |(en & ~(N_SRC'(1) << i));
    assign want      = (sel == SEL_W'(i)) && !others_on;

    always_ff @(posedge src_clk[i]) begin
      if (rst) sync_q <= 1'(i == 0);
      else     sync_q <= want;
    end

    // enable changes while this lane's clock is low: no partial pulse
    always_ff @(negedge src_clk[i]) begin
      if (rst) en_q <= 1'(i == 0);
      else     en_q <= sync_q;
    end

    assign en[i]    = en_q;
    assign gated[i] = src_clk[i] & en_q;
  end

  assign mclk = |gated;

endmodule

// File: rtl/cfgclk_cfg_reg.sv
module cfgclk_cfg_reg #(
  parameter int CODE_W   = cfgclk_pkg::CODE_W,
  parameter int RST_CODE = 1
) (
  input  logic              mclk,
  input  logic              rst,
  input  logic              ld,
  input  logic              src_sel,
  input  logic [CODE_W-1:0] div_code,
  input  logic              apply,
  output logic              pend,
  output logic [CODE_W-1:0] code_q,
  output logic              src_q
);

  logic              ld_q;
  logic              ld_rise;
  logic [CODE_W-1:0] pend_code;
  logic              pend_src;

  assign ld_rise = ld && !ld_q;

  always_ff @(posedge mclk) begin
    if (rst) begin
      ld_q      <= 1'b0;
      pend      <= 1'b0;
      pend_code <= CODE_W'(RST_CODE);
      pend_src  <= 1'b0;
      code_q    <= CODE_W'(RST_CODE);
      src_q     <= 1'b0;
    end else begin
      ld_q <= ld;
      if (apply) begin
        code_q <= pend_code;
        src_q  <= pend_src;
      end
      if (ld_rise) begin
        pend      <= 1'b1;
        pend_code <= div_code;
        pend_src  <= src_sel;
      end else if (apply) begin
        pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cfgclk_edge_gen.sv
module cfgclk_edge_gen #(
  parameter int HP_W   = cfgclk_pkg::HP_W,
  parameter int HI_W   = cfgclk_pkg::HI_W,
  parameter int SETTLE = 4,
  localparam int CNT_W = (SETTLE > 2) ? $clog2(SETTLE) : 1
) (
  input  logic            mclk,
  input  logic            rst,
  input  logic            pend,
  input  logic [HP_W-1:0] per,
  input  logic [HI_W-1:0] hi,
  output logic            apply,
  output logic            hold,
  output logic            clk_out,
  output logic            running
);
  import cfgclk_pkg::*;

  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE - 1);

  gen_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [HP_W-1:0]  hp;      // index of the half-period begun at the last rising edge
  logic             t_p;
  logic             t_n;

  logic [HP_W:0]    sum1, sum2, per_w;
  logic [HP_W-1:0]  nxt1, nxt2, hi_e;
  logic             low1, low2, wrap, restart;
  logic             want_p, want_n, out_w;

  always_comb begin
    per_w = {1'b0, per};
    sum1  = {1'b0, hp} + (HP_W+1)'(1);
    sum2  = {1'b0, hp} + (HP_W+1)'(2);
    nxt1  = (sum1 >= per_w) ? HP_W'(sum1 - per_w) : HP_W'(sum1);
    nxt2  = (sum2 >= per_w) ? HP_W'(sum2 - per_w) : HP_W'(sum2);
    hi_e  = HP_W'(hi);
    low1  = nxt1 >= hi_e;
    low2  = nxt2 >= hi_e;
    wrap  = sum2 >= per_w;
    restart = (st == ST_HOLD) && (cnt == SETTLE_LAST);
    // cut only where no high phase is shortened
    apply = (st == ST_RUN) && pend && (low1 || low2);
    out_w = t_p ^ t_n;
    if (st == ST_RUN) want_p = !apply && !low2;
    else              want_p = restart;
    want_n = (st == ST_RUN) && !low1;
  end

  always_ff @(posedge mclk) begin
    if (rst) begin
      st      <= ST_HOLD;
      cnt     <= '0;
      hp      <= '0;
      t_p     <= 1'b0;
      running <= 1'b0;
    end else begin
      t_p <= t_p ^ (want_p ^ out_w);
      unique case (st)
        ST_RUN: begin
          if (apply) begin
            st      <= ST_HOLD;
            cnt     <= '0;
            running <= 1'b0;
          end else begin
            hp <= nxt2;
            if (wrap) running <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (restart) begin
            st <= ST_RUN;
            hp <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  always_ff @(negedge mclk) begin
    if (rst) t_n <= 1'b0;
    else     t_n <= t_n ^ (want_n ^ out_w);
  end

  assign hold    = (st == ST_HOLD);
  assign clk_out = out_w;

endmodule

// File: rtl/cfgclk_div.sv
module cfgclk_div #(
  parameter int CODE_W   = cfgclk_pkg::CODE_W,
  parameter int SETTLE   = 4,
  parameter int RST_CODE = 1
) (
  input  logic              clk_int,
  input  logic              clk_ext,
  input  logic              rst,
  input  logic              src_sel,
  input  logic [CODE_W-1:0] div_code,
  input  logic              ld,
  output logic              clk_out,
  output logic              running
);
  import cfgclk_pkg::*;

  localparam int N_SRC = 2;

  logic              mclk;
  logic [N_SRC-1:0]  en;
  logic              pend;
  logic              apply;
  logic              hold;
  logic [CODE_W-1:0] code_q;
  logic              src_q;
  ratio_t            ratio;

  cfgclk_src_gate #(.N_SRC(N_SRC)) gate_i (
    .src_clk ({clk_ext, clk_int}),
    .rst     (rst),
    .sel     (src_q),
    .mclk    (mclk),
    .en      (en)
  );

  cfgclk_cfg_reg #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) cfg_i (
    .mclk     (mclk),
    .rst      (rst),
    .ld       (ld),
    .src_sel  (src_sel),
    .div_code (div_code),
    .apply    (apply),
    .pend     (pend),
    .code_q   (code_q),
    .src_q    (src_q)
  );

  assign ratio = ratio_of(code_q);

  cfgclk_edge_gen #(.HP_W(HP_W), .HI_W(HI_W), .SETTLE(SETTLE)) gen_i (
    .mclk    (mclk),
    .rst     (rst),
    .pend    (pend),
    .per     (ratio.per),
    .hi      (ratio.hi),
    .apply   (apply),
    .hold    (hold),
    .clk_out (clk_out),
    .running (running)
  );

endmodule

// File: rtl/cfgclk_div_chk.sv
module cfgclk_div_chk #(
  parameter int CODE_W = cfgclk_pkg::CODE_W
) (
  input logic              clk_int,
  input logic              mclk,
  input logic              rst,
  input logic [1:0]        en,
  input logic              src_q,
  input logic              hold,
  input logic              clk_out,
  input logic              running,
  input logic [CODE_W-1:0] code_q
);

  AST_ONE_SOURCE: assert property (@(posedge clk_int) disable iff (rst)
    !(en[0] && en[1])); // R9

  AST_RESET_QUIET: assert property (@(posedge mclk) disable iff (rst)
    $past(rst) |-> !running); // R8

  AST_HOLD_LOW: assert property (@(posedge mclk) disable iff (rst)
    hold |-> !clk_out); // R6

  AST_RUN_ON_SELECTED: assert property (@(posedge mclk) disable iff (rst)
    running |-> (src_q ? en[1] : en[0])); // R1

  AST_CODE_ONLY_ON_LOAD: assert property (@(posedge mclk) disable iff (rst)
    (running && $past(running)) |-> $stable(code_q)); // R5

endmodule

bind cfgclk_div cfgclk_div_chk #(.CODE_W(CODE_W)) chk_i (
  .clk_int (clk_int),
  .mclk    (mclk),
  .rst     (rst),
  .en      (en),
  .src_q   (src_q),
  .hold    (hold),
  .clk_out (clk_out),
  .running (running),
  .code_q  (code_q)
);

// File: tb/cfgclk_div_tb_top.sv
`timescale 1ns/1ps
module cfgclk_div_tb_top;

  localparam real T_INT = 4.0;
  localparam real T_EXT = 7.0;

  logic       clk_int = 1'b0;
  logic       clk_ext = 1'b0;
  logic       rst = 1'b1;
  logic       src_sel = 1'b0;
  logic [4:0] div_code = 5'd1;
  logic       ld = 1'b0;
  logic       clk_out;
  logic       running;

  int  n_checks = 0;
  int  n_errors = 0;
  int  runts = 0;
  bit  mon = 1'b0;
  real last_r = 0.0;
  real last_f = 0.0;

  cfgclk_div dut_i (
    .clk_int  (clk_int),
    .clk_ext  (clk_ext),
    .rst      (rst),
    .src_sel  (src_sel),
    .div_code (div_code),
    .ld       (ld),
    .clk_out  (clk_out),
    .running  (running)
  );

  initial forever #(T_INT/2.0) clk_int = ~clk_int;
  initial begin
    #0.7;
    forever #(T_EXT/2.0) clk_ext = ~clk_ext;
  end

  // pulse-width monitor for R6
  always @(posedge clk_out) begin
    if (mon && last_f > 0.0 && ($realtime - last_f) < 1.99) runts++;
    last_r = $realtime;
  end
  always @(negedge clk_out) begin
    if (mon && last_r > 0.0 && ($realtime - last_r) < 1.99) runts++;
    last_f = $realtime;
  end

  task automatic chk(input bit ok, input string tag, input real act, input real exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
    end
  endtask

  task automatic chk_real(input string tag, input real act, input real exp);
    chk((act - exp) < 0.01 && (act - exp) > -0.01, tag, act, exp);
  endtask

  // move to a time ending in .5 ns, away from every clock edge
  task automatic align();
    real t, f;
    t = $realtime;
    f = t - $floor(t);
    if (f < 0.5) #(0.5 - f);
    else         #(1.5 - f);
  endtask

  task automatic wait_level(input logic val, input int steps, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < steps; i++) begin
      if (running == val) begin
        ok = 1'b1;
        break;
      end
      #1;
    end
  endtask

  task automatic measure(output real per, output real hi);
    real t0, t1, t2;
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
    align();
  endtask

  // expected half-period counts, from the code map in R2, R3, R4
  function automatic void expect_ratio(input int c, output int per_h, output int hi_h);
    if (c >= 1 && c <= 16) begin per_h = 2 * c; hi_h = c; end
    else if (c == 17)      begin per_h = 3;     hi_h = 1; end
    else if (c == 18)      begin per_h = 5;     hi_h = 2; end
    else                   begin per_h = 2;     hi_h = 1; end
  endfunction

  task automatic load(input logic s, input int c);
    bit ok;
    src_sel  = s;
    div_code = 5'(c);
    #1;
    ld = 1'b1;
    wait_level(1'b0, 400, ok);
    chk(ok, "R7 running falls after load", real'(running), 0.0);
    chk(clk_out == 1'b0, "R6 output low at switchover", real'(clk_out), 0.0);
    #2;
    ld = 1'b0;
    wait_level(1'b1, 600, ok);
    chk(ok, "R7 running rises after first period", real'(running), 1.0);
  endtask

  task automatic check_ratio(input logic s, input int c, input string tag);
    int  ph, hh;
    real half, per, hi;
    expect_ratio(c, ph, hh);
    half = (s ? T_EXT : T_INT) / 2.0;
    measure(per, hi);
    measure(per, hi);
    chk_real($sformatf("%s period src=%0d code=%0d", tag, s, c), per, ph * half);
    chk_real($sformatf("%s high src=%0d code=%0d", tag, s, c), hi, hh * half);
  endtask

  initial begin
    bit  ok;
    real per, hi;
    #20.5;
    // R8: quiet during reset
    chk(clk_out == 1'b0, "R8 clk_out low in reset", real'(clk_out), 0.0);
    chk(running == 1'b0, "R8 running low in reset", real'(running), 0.0);
    #20;
    rst = 1'b0;
    mon = 1'b1;
    wait_level(1'b1, 600, ok);
    chk(ok, "R8 running rises after reset", real'(running), 1.0);
    check_ratio(1'b0, 1, "R8 default");

    // R1 R9: same code, each source
    load(1'b0, 5);
    check_ratio(1'b0, 5, "R1 R9 internal");
    load(1'b1, 5);
    check_ratio(1'b1, 5, "R1 R9 external");

    // sweep every code on both sources
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 32; c++) begin
        string tag;
        if (c >= 1 && c <= 16)      tag = "R2";
        else if (c == 17 || c == 18) tag = "R3";
        else                         tag = "R4";
        load(1'(s), c);
        check_ratio(1'(s), c, tag);
      end
    end

    // R5: new inputs without a load strobe are ignored
    load(1'b0, 3);
    src_sel  = 1'b1;
    div_code = 5'd9;
    #200;
    chk(running == 1'b1, "R5 running kept without load", real'(running), 1.0);
    check_ratio(1'b0, 3, "R5 unchanged");

    // R6: no short pulses over the whole run
    chk(runts == 0, "R6 no runt pulses", real'(runts), 0.0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule